// File: doc/BRIEF.md
# Fully Associative Victim Line Buffer

This block sits between a direct-mapped cache and the next memory level. It keeps a small set of whole cache lines that the direct-mapped array has thrown out, so that a line lost to a conflict can be recovered without a trip to the next level. Every entry has its own tag comparator, and all entries are searched at once.

When the direct-mapped cache misses, it sends one request. The request carries the full line address of the missing line. It may also carry the line the cache is about to discard from that index, with its address, data and dirty flag. On a buffer hit the two lines trade places: the matching entry hands its line back to the cache, and the same slot takes the discarded line. If no discarded line comes with the request, the slot is freed. On a miss the discarded line is written into a free slot. If no slot is free, it overwrites the entry that was inserted longest ago. That displaced entry goes to the next level only when it is dirty. A discarded line can also be pushed in without a probe, for example on a plain eviction.

Tags hold the complete line address, because a line from any cache index may sit in any slot. Results are registered and appear one clock after the request.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is empty, `rsp_valid` and `wb_valid` are 0, and any probe misses until a line has been inserted.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1. `rsp_hit` is 1 only when the probed line address equals the address of a resident entry.
- R3: On a hit, `rsp_data` and `rsp_dirty` carry the data and dirty flag that were stored with that line.
- R4: A hit removes the line from the buffer. When `evict_valid` is 1 in the same cycle, the freed slot takes the discarded line; otherwise the slot becomes empty. A repeated probe of the same address then misses.
- R5: A discarded line that misses goes into an empty slot whenever one exists, and no line is sent out in that case.
- R6: When all slots are full, an inserted line replaces the resident line that was inserted earliest. A line swapped in on a hit counts as the newest.
- R7: A displaced line whose dirty flag is 1 appears on `wb_valid`/`wb_addr`/`wb_data` one cycle after the insertion. A displaced clean line produces no output.
- R8: With `req_valid` = 0 and `evict_valid` = 1, the line is inserted under the same rules as on a probe miss.
- R9: A swap on a hit never drives `wb_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Probe request from a direct-mapped miss |
| req_addr | input | ADDR_W | Full line address being probed |
| evict_valid | input | 1 | A discarded line accompanies this cycle |
| evict_addr | input | ADDR_W | Full line address of the discarded line |
| evict_data | input | DATA_W | Data of the discarded line |
| evict_dirty | input | 1 | Dirty flag of the discarded line |
| rsp_valid | output | 1 | Probe result valid (one cycle after the request) |
| rsp_hit | output | 1 | Probe found the line |
| rsp_data | output | DATA_W | Line data returned on a hit |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| wb_valid | output | 1 | A dirty displaced line goes to the next level |
| wb_addr | output | ADDR_W | Line address of the displaced line |
| wb_data | output | DATA_W | Data of the displaced line |

## Verification
The checkers assume that a discarded line's address is never already resident in the buffer and never equals the address probed in the same cycle. That is why at most one comparator can match. The stimulus picks each discarded address from a pool, leaves out every address the reference model currently holds and the probed address, and draws again until both conditions are met. Probes are drawn from the same small pool, so hits, swaps, FIFO displacement of both dirty and clean lines, and refills of freed slots all happen often.

// File: rtl/victim_buf_pkg.sv
package victim_buf_pkg;
  localparam int unsigned VB_ENTRIES_DEF = 4;
  localparam int unsigned VB_ADDR_W_DEF  = 26;
  localparam int unsigned VB_DATA_W_DEF  = 64;

  typedef enum logic [1:0] {
    VB_ACT_IDLE = 2'd0,
    VB_ACT_SWAP = 2'd1,
    VB_ACT_TAKE = 2'd2,
    VB_ACT_FILL = 2'd3
  } vb_act_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hit_vec,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == key);
  end

  assign hit_vec = eq;
  assign hit     = |eq;

  always_comb begin
    hit_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (eq[j]) hit_idx = hit_idx | IW'(j);
    end
  end
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][IW-1:0] age,
  output logic [IW-1:0]        slot,
  output logic                 full
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  always_comb begin
    full = &valid;
    slot = '0;
    if (full) begin
      for (int j = 0; j < N; j++) begin
        if (age[j] == OLDEST) slot = IW'(j);
      end
    end else begin
      for (int j = N - 1; j >= 0; j--) begin
        if (!valid[j]) slot = IW'(j);
      end
    end
  end
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_en,
  input  logic [IW-1:0]        ins_idx,
  input  logic                 rem_en,
  input  logic [IW-1:0]        rem_idx,
  input  logic [N-1:0]         valid,
  output logic [N-1:0][IW-1:0] age
);
  localparam logic [IW:0] ALL_RANKS = (IW+1)'(N);

  logic [N-1:0][IW-1:0] age_q, age_d;
  logic [IW:0]          thr;
  logic                 age_en;

  // rank 0 = newest insertion; valid entries always hold distinct ranks
  always_comb begin
    thr   = valid[ins_idx] ? {1'b0, age_q[ins_idx]} : ALL_RANKS;
    age_d = age_q;
    for (int j = 0; j < N; j++) begin
      if (ins_en) begin
        if (IW'(j) == ins_idx) begin
          age_d[j] = '0;
        end else if (valid[j] && ({1'b0, age_q[j]} < thr)) begin
          age_d[j] = age_q[j] + IW'(1);
        end
      end else if (rem_en) begin
        if (valid[j] && (age_q[j] > age_q[rem_idx])) begin
          age_d[j] = age_q[j] - IW'(1);
        end
      end
    end
  end

  assign age_en = ins_en || rem_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_en) begin
      age_q <= age_d;
    end
  end

  assign age = age_q;
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import victim_buf_pkg::*;
#(
  parameter int unsigned N      = VB_ENTRIES_DEF,
  parameter int unsigned ADDR_W = VB_ADDR_W_DEF,
  parameter int unsigned DATA_W = VB_DATA_W_DEF,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // entry storage
  logic [N-1:0]             valid_q, valid_d;
  logic [N-1:0]             dirty_q, dirty_d;
  logic [N-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [N-1:0][DATA_W-1:0] data_q, data_d;

  logic [N-1:0]         hit_vec;
  logic                 hit_any;
  logic [IW-1:0]        hit_idx;
  logic [N-1:0][IW-1:0] age;
  logic [IW-1:0]        alloc_idx;
  logic                 full;

  vb_match #(.N(N), .AW(ADDR_W)) u_match (
    .valid   (valid_q),
    .tags    (tag_q),
    .key     (req_addr),
    .hit_vec (hit_vec),
    .hit     (hit_any),
    .hit_idx (hit_idx)
  );

  vb_alloc #(.N(N)) u_alloc (
    .valid (valid_q),
    .age   (age),
    .slot  (alloc_idx),
    .full  (full)
  );

  // action decode
  vb_act_e       act;
  logic          ins_en, rem_en, push_out, wb_fire;
  logic [IW-1:0] ins_idx;

  always_comb begin
    if (req_valid && hit_any) act = evict_valid ? VB_ACT_SWAP : VB_ACT_TAKE;
    else if (evict_valid)     act = VB_ACT_FILL;
    else                      act = VB_ACT_IDLE;
  end

  assign ins_en   = (act == VB_ACT_SWAP) || (act == VB_ACT_FILL);
  assign rem_en   = (act == VB_ACT_TAKE);
  assign ins_idx  = (act == VB_ACT_SWAP) ? hit_idx : alloc_idx;
  assign push_out = (act == VB_ACT_FILL) && full;
  assign wb_fire  = push_out && dirty_q[alloc_idx];

  vb_age #(.N(N)) u_age (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ins_en  (ins_en),
    .ins_idx (ins_idx),
    .rem_en  (rem_en),
    .rem_idx (hit_idx),
    .valid   (valid_q),
    .age     (age)
  );

  // storage next state
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    tag_d   = tag_q;
    data_d  = data_q;
    if (ins_en) begin
      valid_d[ins_idx] = 1'b1;
      dirty_d[ins_idx] = evict_dirty;
      tag_d[ins_idx]   = evict_addr;
      data_d[ins_idx]  = evict_data;
    end else if (rem_en) begin
      valid_d[hit_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (ins_en || rem_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  // registered results
  logic              rsp_valid_q, rsp_hit_q, rsp_dirty_q, wb_valid_q;
  logic [DATA_W-1:0] rsp_data_q, wb_data_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic              take_hit;

  assign take_hit = (act == VB_ACT_SWAP) || (act == VB_ACT_TAKE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      wb_valid_q  <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_hit_q   <= take_hit;
      wb_valid_q  <= wb_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (take_hit) begin
      rsp_data_q  <= data_q[hit_idx];
      rsp_dirty_q <= dirty_q[hit_idx];
    end
    if (wb_fire) begin
      wb_addr_q <= tag_q[alloc_idx];
      wb_data_q <= data_q[alloc_idx];
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_dirty = rsp_dirty_q;
  assign wb_valid  = wb_valid_q;
  assign wb_addr   = wb_addr_q;
  assign wb_data   = wb_data_q;
endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         evict_valid,
  input logic         hit_any,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] valid_q,
  input logic         full,
  input logic         rsp_valid,
  input logic         rsp_hit,
  input logic         wb_valid
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_hit_needs_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_swap_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_any && evict_valid) |=> ($countones(valid_q) == $past($countones(valid_q))));

  p_take_frees_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_any && !evict_valid) |=> ($countones(valid_q) + 1 == $past($countones(valid_q))));

  p_no_wb_with_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !full |=> !wb_valid);

  p_wb_needs_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |=> !wb_valid);

  p_no_wb_on_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_any) |=> !wb_valid);
endmodule

bind victim_buf victim_buf_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_valid   (req_valid),
  .evict_valid (evict_valid),
  .hit_any     (hit_any),
  .hit_vec     (hit_vec),
  .valid_q     (valid_q),
  .full        (full),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .wb_valid    (wb_valid)
);

// File: tb/victim_buf_tb.sv
`timescale 1ns/1ps
module victim_buf_tb;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, evict_valid, evict_dirty;
  logic [AW-1:0] req_addr, evict_addr;
  logic [DW-1:0] evict_data;
  logic          rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  always #2.5 clk = ~clk;

  victim_buf #(.N(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .evict_data(evict_data), .evict_dirty(evict_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  // behavioural reference: slots plus insertion-order queue
  bit            mv [N];
  bit            mdy[N];
  logic [AW-1:0] ma [N];
  logic [DW-1:0] md [N];
  int            ord[$];

  function automatic logic [AW-1:0] A(input int n);
    return AW'(32'h100 + n);
  endfunction

  function automatic logic [DW-1:0] D(input int n);
    return {32'hDA7A_0000, 32'(n * 7 + 3)};
  endfunction

  function automatic int mfind(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic rq, input logic [AW-1:0] ra,
                      input logic ev, input logic [AW-1:0] ea, input logic edy);
    bit            e_hit, e_wb, e_dy;
    logic [DW-1:0] e_data, e_wbd;
    logic [AW-1:0] e_wba;
    int            k;
    e_hit = 0; e_wb = 0; e_dy = 0; e_data = '0; e_wbd = '0; e_wba = '0;
    req_valid = rq; req_addr = ra; evict_valid = ev; evict_addr = ea;
    evict_data = D(int'(ea)); evict_dirty = edy;
    k = rq ? mfind(ra) : -1;
    if (k >= 0) begin
      e_hit = 1; e_data = md[k]; e_dy = mdy[k];
      for (int p = 0; p < ord.size(); p++) if (ord[p] == k) begin ord.delete(p); break; end
      if (ev) begin
        ma[k] = ea; md[k] = D(int'(ea)); mdy[k] = edy; ord.push_back(k);
      end else mv[k] = 0;
    end else if (ev) begin
      k = -1;
      for (int i = 0; i < N; i++) if (!mv[i] && k < 0) k = i;
      if (k < 0) begin
        k = ord.pop_front();
        if (mdy[k]) begin e_wb = 1; e_wba = ma[k]; e_wbd = md[k]; end
      end
      mv[k] = 1; ma[k] = ea; md[k] = D(int'(ea)); mdy[k] = edy; ord.push_back(k);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rsp_valid", DW'(rsp_valid), DW'(rq));
    if (rq) check(tag, "rsp_hit", DW'(rsp_hit), DW'(e_hit));
    if (rq && e_hit) begin
      check(tag, "rsp_data", rsp_data, e_data);
      check(tag, "rsp_dirty", DW'(rsp_dirty), DW'(e_dy));
    end
    check(tag, "wb_valid", DW'(wb_valid), DW'(e_wb));
    if (e_wb) begin
      check(tag, "wb_addr", DW'(wb_addr), DW'(e_wba));
      check(tag, "wb_data", wb_data, e_wbd);
    end
    req_valid = 0; evict_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mdy[i] = 0; ma[i] = '0; md[i] = '0; end
    req_valid = 0; evict_valid = 0; evict_dirty = 0;
    req_addr = '0; evict_addr = '0; evict_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state and empty buffer
    check("R1", "rsp_valid after reset", DW'(rsp_valid), '0);
    check("R1", "wb_valid after reset", DW'(wb_valid), '0);
    step("R1", 1, A(0), 0, '0, 0);

    // R8: insert without probe; R5: fill free slots without line-out
    step("R8", 0, '0, 1, A(1), 1);
    step("R5", 1, A(9), 1, A(2), 0);
    step("R5", 1, A(10), 1, A(3), 1);
    step("R5", 1, A(11), 1, A(4), 0);
    check("R5", "no line-out when filling last slot", DW'(wb_valid), '0);

    // R3/R9: hit returns line, swap in discarded line, no line-out
    step("R3", 1, A(2), 1, A(5), 1);
    check("R3", "hit data of A2", rsp_data, D(int'(A(2))));
    check("R9", "no line-out on swap", DW'(wb_valid), '0);

    // R4: swapped-out address now misses
    step("R4", 1, A(2), 0, '0, 0);
    check("R4", "repeat probe misses", DW'(rsp_hit), '0);

    // R6/R7: FIFO displacement, dirty goes out
    step("R6", 1, A(12), 1, A(6), 1);
    check("R6", "oldest A1 displaced", DW'(wb_addr), DW'(A(1)));
    step("R7", 1, A(13), 1, A(7), 0);
    check("R7", "dirty A3 written back", DW'(wb_addr), DW'(A(3)));
    step("R7", 0, '0, 1, A(8), 0);
    check("R7", "clean A4 dropped silently", DW'(wb_valid), '0);
    step("R6", 0, '0, 1, A(14), 0);
    check("R6", "swapped-in A5 displaced after A4", DW'(wb_addr), DW'(A(5)));

    // R4: hit without discarded line frees the slot; R5: refill without line-out
    step("R4", 1, A(6), 0, '0, 0);
    step("R4", 1, A(6), 0, '0, 0);
    check("R4", "taken line misses", DW'(rsp_hit), '0);
    step("R5", 0, '0, 1, A(15), 1);
    check("R5", "hole refilled without line-out", DW'(wb_valid), '0);

    // mixed traffic against the reference model
    for (int c = 0; c < 600; c++) begin
      logic          rq, ev, dy;
      logic [AW-1:0] ra, ea;
      rq = ($urandom_range(0, 3) != 0);
      ev = ($urandom_range(0, 2) != 0);
      dy = $urandom_range(0, 1) == 1;
      ra = A(int'($urandom_range(0, 11)));
      ea = '0;
      if (ev) begin
        ea = A(int'($urandom_range(0, 11)));
        while (mfind(ea) >= 0 || (rq && ea == ra)) ea = A(int'($urandom_range(0, 11)));
      end
      step("R3", rq, ra, ev, ea, dy);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule